// File: doc/BRIEF.md
# Six-Channel PWM Output Override Unit

This block sits between a three-phase complementary PWM modulator and the six pins that drive the power stage. Each phase has a high-side pin and a low-side pin. For each pin, the block either passes the modulator signal through or holds the pin at a configurable "off" level. The modulator keeps running whatever the overrides do. Only the pin drive changes.

Two small registers are reached through a plain single-cycle write strobe and a combinational read path. The control register holds a global override enable and two off-level bits: one for all high-side pins and one for all low-side pins. The override register holds one bit per pin. A fault input takes priority over everything. While it is high, all six pins sit at their off levels within the same cycle, with no clock edge needed. Every interface is control-type, so there is no valid/ready handshake.

Pin index `i` is `2*phase + side`, where side is 0 for high and 1 for low. The same index selects the override bit.

Top module: `pwm_ovr_unit`

## Requirements
- R1: After reset, both registers read 0, given the default off-level parameters of 0. The enable is 0, and every pin follows its modulator input.
- R2: Register address 0 is the control register: bit 0 is the enable, bit 1 the high-side off level, bit 2 the low-side off level. Address 1 is the override register: bit i controls pin i (bit 0 = phase 0 high, bit 1 = phase 0 low, and so on up to bit 5 = phase 2 low). A write takes effect at the clock edge on which `reg_wr` is sampled high.
- R3: With the enable set and no fault, a pin whose override bit is 0 follows its modulator input, including while the input toggles.
- R4: With the enable set and no fault, a pin whose override bit is 1 is held at its side's off level. Even pins use the high-side level and odd pins the low-side level.
- R5: With the enable clear, override bits have no effect, and every pin follows its modulator input.
- R6: Changing the off-level bits changes the forced level of overridden pins. High-side and low-side pins are set independently.
- R7: While `fault_in` is high, all six pins take their off levels in the same cycle, whatever the enable and override bits are. When the fault clears, normal control resumes.
- R8: Reserved bits are ignored on write and read as 0. These are bits 7:6 of the override register and bits 7:3 of the control register.
- R9: Addresses 2 and 3 read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| fault_in | input | 1 | Fault; forces all pins to their off levels |
| pwm_in | input | 6 | Modulator outputs, index 2*phase+side |
| pwm_out | output | 6 | Pin drive, same indexing |

## Verification
The bench walks a single override bit across all six positions with distinct off levels for the two sides. A design with swapped bit order, or with the high and low off levels crossed, would force the wrong pin or drive it to the wrong level. It raises the fault between clock edges with the enable both clear and set. A registered fault path would leave the pins live for up to a cycle. It writes all-ones to both registers and to the unmapped addresses. A design that kept reserved bits, or decoded only one address bit, would read back extra ones or corrupt the override settings.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_OVR  = 1;
  localparam int CTRL_BITS = 3;

  typedef struct packed {
    logic lo_off;
    logic hi_off;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pwm_ovr_regs.sv
module pwm_ovr_regs
  import pwm_ovr_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter int   ADDR_W     = 2,
  parameter int   PINS       = 6,
  parameter logic HI_OFF_RST = 1'b0,
  parameter logic LO_OFF_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic [PINS-1:0]   ovr
);
  localparam logic [DATA_W-1:0] OVR_MASK  = DATA_W'((1 << PINS) - 1);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_BITS) - 1);
  localparam logic [DATA_W-1:0] CTRL_RST  =
    DATA_W'({LO_OFF_RST, HI_OFF_RST, 1'b0});

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ovr_q;
  logic              sel_ctrl, sel_ovr;

  assign sel_ctrl = (addr == ADDR_W'(ADDR_CTRL));
  assign sel_ovr  = (addr == ADDR_W'(ADDR_OVR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ovr_q  <= '0;
    end else if (wr) begin
      if (sel_ctrl) ctrl_q <= wdata & CTRL_MASK;
      if (sel_ovr)  ovr_q  <= wdata & OVR_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl)     rdata = ctrl_q;
    else if (sel_ovr) rdata = ovr_q;
  end

  assign ctrl = ctrl_t'(ctrl_q[CTRL_BITS-1:0]);
  assign ovr  = ovr_q[PINS-1:0];

  // R2: an override write lands on the next edge
  a_r2_ovr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_ovr) |=> (ovr == $past(wdata[PINS-1:0])));

  // R8: reserved bits never read back as 1
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ovr && ((rdata & ~OVR_MASK) == '0)) ||
    (sel_ctrl && ((rdata & ~CTRL_MASK) == '0)) || (!sel_ovr && !sel_ctrl));

  // R9: unmapped writes leave both registers alone
  a_r9_unmapped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sel_ctrl && !sel_ovr) |=> ($stable(ovr) && $stable(ctrl)));
endmodule

// File: rtl/pwm_ovr_pin.sv
module pwm_ovr_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm,
  input  logic ovr_bit,
  input  logic en,
  input  logic fault,
  input  logic off_lvl,
  output logic out
);
  logic force_off;

  assign force_off = fault | (en & ovr_bit);
  assign out       = force_off ? off_lvl : pwm;

  // R4: an enabled override holds the pin at its off level
  a_r4_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ovr_bit) |-> (out == off_lvl));
endmodule

// File: rtl/pwm_ovr_unit.sv
module pwm_ovr_unit
  import pwm_ovr_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter int   ADDR_W     = 2,
  parameter int   PHASES     = 3,
  parameter logic HI_OFF_RST = 1'b0,
  parameter logic LO_OFF_RST = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                fault_in,
  input  logic [2*PHASES-1:0] pwm_in,
  output logic [2*PHASES-1:0] pwm_out
);
  localparam int PINS = 2 * PHASES;

  ctrl_t           ctrl;
  logic [PINS-1:0] ovr;
  logic [PINS-1:0] off_vec;

  pwm_ovr_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PINS(PINS),
    .HI_OFF_RST(HI_OFF_RST), .LO_OFF_RST(LO_OFF_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl), .ovr(ovr)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    if ((i % 2) == 0) begin : g_hi
      assign off_vec[i] = ctrl.hi_off;
    end else begin : g_lo
      assign off_vec[i] = ctrl.lo_off;
    end
    pwm_ovr_pin u_pin (
      .clk(clk), .rst_n(rst_n), .pwm(pwm_in[i]), .ovr_bit(ovr[i]),
      .en(ctrl.en), .fault(fault_in), .off_lvl(off_vec[i]), .out(pwm_out[i])
    );
  end

  // R7: fault drives every pin to its off level
  a_r7_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |-> (pwm_out == off_vec));

  // R5: with the enable clear and no fault the pins follow the modulator
  a_r5_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_in && !ctrl.en) |-> (pwm_out == pwm_in));

  // R3: pins without an override follow the modulator
  a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_in && ovr == '0) |-> (pwm_out == pwm_in));
endmodule

// File: tb/sim_pwm_ovr_unit.sv
`timescale 1ns/1ps
module sim_pwm_ovr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       fault_in = 1'b0;
  logic [5:0] pwm_in = '0;
  logic [5:0] pwm_out;

  int checks = 0;
  int errors = 0;

  // Bench copy of the register state, written from the requirements.
  logic       m_en = 1'b0, m_hi = 1'b0, m_lo = 1'b0;
  logic [5:0] m_ovr = '0;

  always #2.5 clk = ~clk;

  pwm_ovr_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_in(fault_in),
    .pwm_in(pwm_in), .pwm_out(pwm_out)
  );

  function automatic logic [5:0] exp_out();
    logic [5:0] off;
    for (int i = 0; i < 6; i++) off[i] = (i % 2 == 0) ? m_hi : m_lo;
    if (fault_in) return off;
    if (m_en) return (pwm_in & ~m_ovr) | (off & m_ovr);
    return pwm_in;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) begin m_en = d[0]; m_hi = d[1]; m_lo = d[2]; end
    if (a == 2'd1) m_ovr = d[5:0];
  endtask

  task automatic chk_rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic chk_pins(input string req);
    #1;
    chk(req, {2'b00, pwm_out}, {2'b00, exp_out()});
  endtask

  task automatic t_reset();
    chk_rd("R1 ctrl", 2'd0, 8'h00);
    chk_rd("R1 ovr", 2'd1, 8'h00);
    pwm_in = 6'b101101; chk_pins("R1 pass");
  endtask

  task automatic t_bitmap();
    wr_reg(2'd0, 8'h03);  // en, hi off=1, lo off=0
    for (int i = 0; i < 6; i++) begin
      wr_reg(2'd1, 8'(1 << i));
      chk_rd("R2 ovr rd", 2'd1, 8'(1 << i));
      pwm_in = 6'b000000; chk_pins("R2/R4 walk low");
      pwm_in = 6'b111111; chk_pins("R2/R4 walk high");
    end
  endtask

  task automatic t_pass();
    wr_reg(2'd1, 8'h00);
    for (int k = 0; k < 8; k++) begin
      pwm_in = 6'(k * 13 + 5); chk_pins("R3 follow");
    end
    wr_reg(2'd1, 8'h15);  // all high pins overridden
    pwm_in = 6'b101010; chk_pins("R3 low pins follow");
    pwm_in = 6'b010101; chk_pins("R4 high pins held");
  endtask

  task automatic t_disable();
    wr_reg(2'd1, 8'h3F);
    wr_reg(2'd0, 8'h06);  // enable clear, both off levels 1
    pwm_in = 6'b000000; chk_pins("R5 disabled");
    pwm_in = 6'b100110; chk_pins("R5 disabled");
    chk(   "R5 literal", {2'b00, pwm_out}, 8'h26);
  endtask

  task automatic t_levels();
    wr_reg(2'd1, 8'h3F);
    pwm_in = 6'b010101;
    wr_reg(2'd0, 8'h07); #1; chk("R6 both 1", {2'b00, pwm_out}, 8'h3F);
    wr_reg(2'd0, 8'h01); #1; chk("R6 both 0", {2'b00, pwm_out}, 8'h00);
    wr_reg(2'd0, 8'h05); #1; chk("R6 lo 1", {2'b00, pwm_out}, 8'h2A);
    wr_reg(2'd0, 8'h03); #1; chk("R6 hi 1", {2'b00, pwm_out}, 8'h15);
  endtask

  task automatic t_fault();
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h02);  // enable clear, hi off 1, lo off 0
    pwm_in = 6'b101010;
    @(negedge clk); #1;
    fault_in = 1'b1; #0.5;
    chk("R7 same cycle", {2'b00, pwm_out}, 8'h15);
    wr_reg(2'd0, 8'h05); wr_reg(2'd1, 8'h3F);
    chk_pins("R7 overrides ignored");
    chk("R7 literal", {2'b00, pwm_out}, 8'h2A);
    @(negedge clk); fault_in = 1'b0;
    wr_reg(2'd1, 8'h01);
    pwm_in = 6'b111110; chk_pins("R7 release");
  endtask

  task automatic t_reserved();
    wr_reg(2'd1, 8'hFF);
    chk_rd("R8 ovr", 2'd1, 8'h3F);
    wr_reg(2'd0, 8'hFF);
    chk_rd("R8 ctrl", 2'd0, 8'h07);
  endtask

  task automatic t_unmapped();
    wr_reg(2'd1, 8'h12);
    wr_reg(2'd0, 8'h01);
    wr_reg(2'd2, 8'hFF);
    wr_reg(2'd3, 8'hFF);
    chk_rd("R9 rd2", 2'd2, 8'h00);
    chk_rd("R9 rd3", 2'd3, 8'h00);
    chk_rd("R9 ovr kept", 2'd1, 8'h12);
    chk_rd("R9 ctrl kept", 2'd0, 8'h01);
    pwm_in = 6'b111111; chk_pins("R9 pins");
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bitmap();
    t_pass();
    t_disable();
    t_levels();
    t_fault();
    t_reserved();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule